// File: doc/BRIEF.md
# Interrupt Cause Coalescing Controller

This block gathers single-cycle event pulses from internal sources into a host-visible cause register. It gates each cause with a per-bit enable and drives one host interrupt line. The host clears handled causes by writing ones to them. The line is not raised on the first enabled cause. A holdoff countdown, programmed in units of 32 microsecond ticks, runs first, so a burst of events costs the host one interrupt instead of many.

Two extra paths sit beside the holdoff. A periodic timer, programmed in the same units, raises a dedicated receive cause each time it expires. A high-priority receive input raises the receive cause and skips the holdoff, so the line is raised on the very next cycle.

The host reaches the block through a simple register bus: write strobe, read strobe, byte address and 32-bit data. Reads are combinational.

Top module: `intc_coalesce`

## Requirements
- R1: After reset the cause register and the enable register read 0, the holdoff word (byte address 0x4) reads 0x00000040, and `irq_o` is low.
- R2: Writing the cause register (byte address 0x8) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R3: When a source sets a cause bit on the same clock edge that a host write clears it, the bit stays set.
- R4: A cause whose enable bit (enable register, byte address 0xC) is 0 is still recorded, but it never raises `irq_o`.
- R5: Only cause bits 31 (receive DMA), 29 (hardware error), 28 (periodic receive), 27 (transmit DMA), 25 (firmware error), 7 (RF kill), 6 (over-temperature), 3 (receive), 1 (wakeup) and 0 (alive) exist. Source input bits go to the same positions, except bit 28, which only the periodic timer sets. The other bits read 0 in both registers. The holdoff word keeps only bits 15:0, and any unmapped address reads 0.
- R6: With holdoff value D (bits 7:0 of the holdoff word) nonzero, the first enabled pending cause that appears while the block is idle starts a countdown of D*32 ticks, beginning one cycle after the cause is recorded. `irq_o` rises in the cycle after the edge that counts the last tick.
- R7: With D = 0, `irq_o` rises one cycle after the enabled cause is recorded.
- R8: `irq_o` stays high while any enabled cause is pending. It drops right after the write edge that clears the last enabled pending cause.
- R9: With period value P (bits 15:8 of the holdoff word) nonzero, bit 28 is set every P*32 ticks, counted from the write of P. P = 0 stops the periodic timer.
- R10: A pulse on `hp_rx_i` sets bit 31. If bit 31 is enabled, `irq_o` rises right after that same edge, even while a holdoff countdown is running.
- R11: The countdowns advance only on edges where `us_tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational, 0 when not reading) |
| cause_i | input | 32 | Single-cycle cause pulses, one per bit position |
| hp_rx_i | input | 1 | High-priority receive event |
| us_tick_i | input | 1 | One-microsecond tick enable |
| irq_o | output | 1 | Host interrupt line |

## Verification
The hardest situations to reach from the ports involve races: a cause arriving on the same edge as the host clear of that bit, and a high-priority event landing in the middle of a long holdoff countdown. The bench makes the set and the clear happen on one edge by driving the cause input and the write strobe together in a single task. It starts a 2048-tick holdoff with an ordinary cause and then pulses the high-priority input a few cycles later. Holdoff and periodic expiries are timed edge by edge from the recording edge. The tick input is held low and then released to show that counting stalls without ticks.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned REG_W = 32;

    // causes that exist in the register
    localparam logic [REG_W-1:0] CAUSE_IMPL = 32'hBA00_00CB;
    // causes that the source vector may set (bit 28 comes from the periodic timer)
    localparam logic [REG_W-1:0] SRC_MASK   = 32'hAA00_00CB;

    localparam int unsigned BIT_RX_DMA   = 31;
    localparam int unsigned BIT_PERIODIC = 28;

    localparam logic [7:0] DELAY_RST  = 8'h40;
    localparam logic [7:0] PERIOD_RST = 8'h00;

    localparam logic [3:0] OFS_COAL = 4'h4;
    localparam logic [3:0] OFS_STAT = 4'h8;
    localparam logic [3:0] OFS_ENAB = 4'hC;

    typedef enum logic [1:0] {
        HOLD_IDLE = 2'd0,
        HOLD_WAIT = 2'd1,
        HOLD_FIRE = 2'd2
    } hold_state_e;

    typedef struct packed {
        logic [7:0] period;
        logic [7:0] delay;
    } coal_cfg_t;

    function automatic logic [REG_W-1:0] one_hot(input int unsigned pos, input logic v);
        logic [REG_W-1:0] r;
        r = '0;
        r[pos] = v;
        return r;
    endfunction

endpackage

// File: rtl/intc_cause_bank.sv
module intc_cause_bank
    import intc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [REG_W-1:0] set_vec_i,
    input  logic             clr_wr_i,
    input  logic [REG_W-1:0] clr_mask_i,
    input  logic             en_wr_i,
    input  logic [REG_W-1:0] en_data_i,
    output logic [REG_W-1:0] stat_o,
    output logic [REG_W-1:0] en_o
);

    logic [REG_W-1:0] stat_q, en_q, clr_eff, set_eff;

    assign clr_eff = clr_wr_i ? clr_mask_i : '0;
    assign set_eff = set_vec_i & CAUSE_IMPL;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= ((stat_q & ~clr_eff) | set_eff) & CAUSE_IMPL;
            if (en_wr_i)
                en_q <= en_data_i & CAUSE_IMPL;
        end
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;

    AST_W1C_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((~stat_q & $past(stat_q) & ~($past(clr_wr_i) ? $past(clr_mask_i) : '0)) == '0)); // R2

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((stat_q & $past(set_vec_i) & CAUSE_IMPL) == ($past(set_vec_i) & CAUSE_IMPL))); // R3

endmodule

// File: rtl/intc_period_gen.sv
module intc_period_gen #(
    parameter int unsigned UNIT_SH = 5,
    localparam int unsigned CNT_W  = 8 + UNIT_SH
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  logic       load_i,
    input  logic [7:0] period_new_i,
    input  logic [7:0] period_cur_i,
    output logic       pulse_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             running, at_end;

    assign running = (period_cur_i != 8'd0);
    assign at_end  = (cnt_q == CNT_W'(1));
    assign pulse_o = running && tick_i && at_end && !load_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= {period_new_i, {UNIT_SH{1'b0}}};
        end else if (running && tick_i) begin
            if (at_end || cnt_q == '0)
                cnt_q <= {period_cur_i, {UNIT_SH{1'b0}}};
            else
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    AST_PERIOD_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |=> !pulse_o); // R9

endmodule

// File: rtl/intc_holdoff_fsm.sv
module intc_holdoff_fsm
    import intc_pkg::*;
#(
    parameter int unsigned UNIT_SH = 5,
    localparam int unsigned CNT_W  = 8 + UNIT_SH
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  logic       pend_any_i,
    input  logic       hp_fire_i,
    input  logic [7:0] delay_i,
    output logic       fire_o
);

    hold_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= HOLD_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                HOLD_IDLE: begin
                    if (hp_fire_i) begin
                        state_q <= HOLD_FIRE;
                    end else if (pend_any_i) begin
                        if (delay_i == 8'd0) begin
                            state_q <= HOLD_FIRE;
                        end else begin
                            cnt_q   <= {delay_i, {UNIT_SH{1'b0}}};
                            state_q <= HOLD_WAIT;
                        end
                    end
                end
                HOLD_WAIT: begin
                    if (hp_fire_i) begin
                        state_q <= HOLD_FIRE;
                    end else if (!pend_any_i) begin
                        state_q <= HOLD_IDLE;
                    end else if (tick_i) begin
                        if (cnt_q <= CNT_W'(1))
                            state_q <= HOLD_FIRE;
                        else
                            cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                HOLD_FIRE: begin
                    if (!pend_any_i && !hp_fire_i)
                        state_q <= HOLD_IDLE;
                end
                default: state_q <= HOLD_IDLE;
            endcase
        end
    end

    assign fire_o = (state_q == HOLD_FIRE);

endmodule

// File: rtl/intc_coalesce.sv
module intc_coalesce
    import intc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned UNIT_TICKS = 32,
    localparam int unsigned UNIT_SH   = $clog2(UNIT_TICKS)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic [31:0]       cause_i,
    input  logic              hp_rx_i,
    input  logic              us_tick_i,
    output logic              irq_o
);

    coal_cfg_t        coal_q;
    coal_cfg_t        coal_new;
    logic             coal_wr, stat_wr, enab_wr;
    logic             per_pulse, pend_any, hp_fire, fire;
    logic [REG_W-1:0] stat, en, set_vec;

    assign coal_wr = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_COAL));
    assign stat_wr = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_STAT));
    assign enab_wr = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_ENAB));
    assign coal_new = coal_cfg_t'(bus_wdata_i[15:0]);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            coal_q.delay  <= DELAY_RST;
            coal_q.period <= PERIOD_RST;
        end else if (coal_wr) begin
            coal_q <= coal_new;
        end
    end

    assign set_vec = (cause_i & SRC_MASK)
                   | one_hot(BIT_RX_DMA, hp_rx_i)
                   | one_hot(BIT_PERIODIC, per_pulse);

    intc_cause_bank u_bank (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .set_vec_i  (set_vec),
        .clr_wr_i   (stat_wr),
        .clr_mask_i (bus_wdata_i),
        .en_wr_i    (enab_wr),
        .en_data_i  (bus_wdata_i),
        .stat_o     (stat),
        .en_o       (en)
    );

    intc_period_gen #(.UNIT_SH(UNIT_SH)) u_period (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .tick_i       (us_tick_i),
        .load_i       (coal_wr),
        .period_new_i (coal_new.period),
        .period_cur_i (coal_q.period),
        .pulse_o      (per_pulse)
    );

    assign pend_any = |(stat & en);
    assign hp_fire  = hp_rx_i && en[BIT_RX_DMA];

    intc_holdoff_fsm #(.UNIT_SH(UNIT_SH)) u_hold (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (us_tick_i),
        .pend_any_i (pend_any),
        .hp_fire_i  (hp_fire),
        .delay_i    (coal_q.delay),
        .fire_o     (fire)
    );

    assign irq_o = fire && pend_any;

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            if (bus_addr_i == ADDR_W'(OFS_COAL))
                bus_rdata_o = {16'h0000, coal_q};
            else if (bus_addr_i == ADDR_W'(OFS_STAT))
                bus_rdata_o = stat;
            else if (bus_addr_i == ADDR_W'(OFS_ENAB))
                bus_rdata_o = en;
        end
    end

    AST_HP_BYPASS: assert property (@(posedge clk_i) disable iff (rst_i)
        (hp_rx_i && en[BIT_RX_DMA] && !enab_wr) |=> irq_o); // R10

    AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
        (stat_wr && ((stat & en & ~bus_wdata_i) == '0) && ((set_vec & en) == '0)) |=> !irq_o); // R8

    AST_NO_MASKED_IRQ: assert property (@(posedge clk_i) disable iff (rst_i)
        (en == '0 && !enab_wr) |=> !irq_o); // R4

endmodule

// File: tb/sim_intc_coalesce.sv
module sim_intc_coalesce;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0, rd = 1'b0, hp = 1'b0, tick = 1'b1;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0, cause = '0, rdata;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    intc_coalesce u0 (
        .clk_i(clk), .rst_i(rst), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .cause_i(cause), .hp_rx_i(hp), .us_tick_i(tick), .irq_o(irq)
    );

    typedef struct packed {
        logic [1:0]  op;    // 0 write, 1 read-compare, 2 cause pulse
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 4'h4, 32'h0,          32'h0000_0040, 8'd1},  // R1
        '{2'd1, 4'h8, 32'h0,          32'h0000_0000, 8'd1},  // R1
        '{2'd1, 4'hC, 32'h0,          32'h0000_0000, 8'd1},  // R1
        '{2'd2, 4'h0, 32'hFFFF_FFFF,  32'h0,         8'd5},
        '{2'd1, 4'h8, 32'h0,          32'hAA00_00CB, 8'd5},  // R5
        '{2'd0, 4'h8, 32'h0000_000F,  32'h0,         8'd2},
        '{2'd1, 4'h8, 32'h0,          32'hAA00_00C0, 8'd2},  // R2
        '{2'd0, 4'h8, 32'h0000_0000,  32'h0,         8'd2},
        '{2'd1, 4'h8, 32'h0,          32'hAA00_00C0, 8'd2},  // R2
        '{2'd0, 4'h8, 32'hFFFF_FFFF,  32'h0,         8'd2},
        '{2'd1, 4'h8, 32'h0,          32'h0000_0000, 8'd2},  // R2
        '{2'd0, 4'hC, 32'hFFFF_FFFF,  32'h0,         8'd5},
        '{2'd1, 4'hC, 32'h0,          32'hBA00_00CB, 8'd5},  // R5
        '{2'd0, 4'hC, 32'h0000_0000,  32'h0,         8'd5},
        '{2'd0, 4'h4, 32'hABCD_0007,  32'h0,         8'd5},
        '{2'd1, 4'h4, 32'h0,          32'h0000_0007, 8'd5},  // R5
        '{2'd1, 4'h0, 32'h0,          32'h0000_0000, 8'd5}   // R5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        rd = 1'b1; addr = a;
        #1;
        d = rdata;
        rd = 1'b0;
    endtask

    task automatic pulse_cause(input logic [31:0] v);
        @(negedge clk);
        cause = v;
        @(negedge clk);
        cause = '0;
    endtask

    task automatic pulse_hp();
        @(negedge clk);
        hp = 1'b1;
        @(negedge clk);
        hp = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                2'd0: bus_write(VECS[i].addr, VECS[i].data);
                2'd1: begin
                    bus_read(VECS[i].addr, r);
                    chk($sformatf("R%0d table %0d", VECS[i].req, i), r, VECS[i].exp);
                end
                default: pulse_cause(VECS[i].data);
            endcase
        end
        chk("R4 no irq with enables off", {31'b0, irq}, 32'h0);

        // R4: disabled cause recorded but silent
        bus_write(4'h4, 32'h0000_0000);
        bus_write(4'hC, 32'h0000_0001);
        pulse_cause(32'h0000_0002);
        repeat (5) @(negedge clk);
        chk("R4 irq stays low", {31'b0, irq}, 32'h0);
        bus_read(4'h8, r);
        chk("R4 cause recorded", r, 32'h0000_0002);
        bus_write(4'h8, 32'hFFFF_FFFF);

        // R6: holdoff of 2 units = 64 ticks
        bus_write(4'hC, 32'h0000_0003);
        bus_write(4'h4, 32'h0000_0002);
        pulse_cause(32'h0000_0001);
        repeat (64) @(negedge clk);
        chk("R6 irq low before expiry", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R6 irq at expiry", {31'b0, irq}, 32'h1);

        // R8: irq held until last enabled cause cleared
        pulse_cause(32'h0000_0002);
        bus_write(4'h8, 32'h0000_0001);
        chk("R8 irq held with one pending", {31'b0, irq}, 32'h1);
        bus_write(4'h8, 32'h0000_0002);
        chk("R8 irq drops on last clear", {31'b0, irq}, 32'h0);

        // R7: zero holdoff
        bus_write(4'h4, 32'h0000_0000);
        pulse_cause(32'h0000_0001);
        chk("R7 irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 irq one cycle later", {31'b0, irq}, 32'h1);
        bus_write(4'h8, 32'h0000_0001);

        // R10: high-priority bypass, alone and during a countdown
        bus_write(4'h4, 32'h0000_0040);
        bus_write(4'hC, 32'h8000_0003);
        pulse_hp();
        chk("R10 immediate irq", {31'b0, irq}, 32'h1);
        bus_read(4'h8, r);
        chk("R10 bit 31 set", r, 32'h8000_0000);
        bus_write(4'h8, 32'h8000_0000);
        chk("R10 irq cleared", {31'b0, irq}, 32'h0);
        pulse_cause(32'h0000_0001);
        repeat (5) @(negedge clk);
        chk("R10 holdoff running", {31'b0, irq}, 32'h0);
        pulse_hp();
        chk("R10 bypass during holdoff", {31'b0, irq}, 32'h1);
        bus_write(4'h8, 32'h8000_0001);
        chk("R10 irq cleared again", {31'b0, irq}, 32'h0);

        // R3: set and clear on one edge
        bus_write(4'hC, 32'h0000_0000);
        @(negedge clk);
        wr = 1'b1; addr = 4'h8; wdata = 32'h0000_0002; cause = 32'h0000_0002;
        @(negedge clk);
        wr = 1'b0; wdata = '0; cause = '0;
        bus_read(4'h8, r);
        chk("R3 set wins", r, 32'h0000_0002);
        bus_write(4'h8, 32'h0000_0002);

        // R9: periodic cause every 32 ticks
        bus_write(4'h4, 32'h0000_0140);
        repeat (31) @(negedge clk);
        bus_read(4'h8, r);
        chk("R9 periodic not yet", r, 32'h0);
        @(negedge clk);
        bus_read(4'h8, r);
        chk("R9 periodic expiry", r, 32'h1000_0000);
        bus_write(4'h4, 32'h0000_0040);
        bus_write(4'h8, 32'h1000_0000);
        repeat (80) @(negedge clk);
        bus_read(4'h8, r);
        chk("R9 periodic disabled", r, 32'h0);

        // R11: no ticks, no countdown
        bus_write(4'hC, 32'h0000_0001);
        bus_write(4'h4, 32'h0000_0001);
        tick = 1'b0;
        pulse_cause(32'h0000_0001);
        repeat (50) @(negedge clk);
        chk("R11 stalled without ticks", {31'b0, irq}, 32'h0);
        tick = 1'b1;
        repeat (31) @(negedge clk);
        chk("R11 one tick short", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R11 fires after ticks", {31'b0, irq}, 32'h1);
        bus_write(4'h8, 32'h0000_0001);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule